// File: doc/BRIEF.md
# Two-Wire Management Slave with Crosspoint Control Registers

This block lets a management host set up a 4x4 signal crosspoint over a two-wire serial bus. It oversamples the bus clock and data lines with the fast system clock. It recognises its own 7-bit bus address and holds the settings that steer the routing core. The address has a fixed upper part of `101` and four strap inputs below it, so up to sixteen copies can share one bus. The data line is open-drain, so the slave never drives it high. It can only pull it low through `sda_oe`, and the bench or board forms the wired-AND line.

Three locations can be reached. Location 0x00 holds the route selection for the four outputs. Location 0x03 holds the control bits. Location 0x04 is a read-only view of the per-input signal-presence flags. A host writes a location with one address byte, one register-pointer byte and one data byte. To read, it sets the pointer, issues a repeated start and readdresses the slave with the read bit set. A mode-enable input gates the whole slave. Every change of its level returns the stored settings to their reset values.

Top module: `smb_regfile`

## Requirements
- R1: The slave pulls SDA low in the ninth (ACK) clock of the first byte after a START only when the byte's upper seven bits equal `101` followed by `strap_addr[3:0]`. On a mismatch it releases SDA in every following ACK clock, and it changes no register until the next START.
- R2: A write sequence consists of START, address with bit0=0, register pointer 0x00, data byte and STOP. Each of the three bytes is ACKed, and `route_cfg` then equals the data byte.
- R3: The control location 0x03 resets to 0x0F. A write stores bits 7:6 and 3:0 and forces bits 5:4 to 0. `ctrl_cfg` and reads of 0x03 both show the result.
- R4: A read sequence consists of START, address with bit0=0, register pointer, repeated START, address with bit0=1, and then eight data bits. The slave returns the selected location MSB first, changes SDA only while SCL is low, and releases SDA after the eighth data bit.
- R5: Location 0x04 reads as `{4'b0000, sig_ok[3:0]}`. A write to it is ACKed and changes nothing.
- R6: A write to an unmapped location (anything other than 0x00, 0x03 or 0x04) is ACKed and discarded. A read of an unmapped location returns 0x00.
- R7: After reset, and on every change of `mode_en` level, `route_cfg` becomes 0x00 and `ctrl_cfg` becomes 0x0F.
- R8: While `mode_en` is 0, the slave never pulls SDA low and ignores all bus traffic.
- R9: If SCL stays low for TIMEOUT_CYC clock cycles during a transaction, the slave releases SDA and returns to idle. Bytes that follow without a new START are not ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Slave enable; any level change resets the registers |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_addr | input | 4 | Low four bits of the slave address |
| sig_ok | input | 4 | Per-input signal presence, 1 = valid signal |
| route_cfg | output | 8 | Location 0x00: two select bits per output |
| ctrl_cfg | output | 8 | Location 0x03: control bits |

## Verification
Most internal faults show up on the wire within one byte. A wrong bit count or state moves the ACK pull-down to the wrong SCL period, which the host reads as a NACK. A wrong pointer or data path shows up in the returned byte of the next read, or directly on `route_cfg` and `ctrl_cfg` right after the STOP. A lost timeout keeps SDA pulled low past TIMEOUT_CYC cycles. A missing mode reset leaves stale settings on the outputs one cycle after `mode_en` changes.

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int          TIMEOUT_CYC = 3_750_000,
  parameter logic [2:0]  ADDR_PREFIX = 3'b101,
  parameter int          RW          = 8,
  parameter logic [RW-1:0] CTRL_RST  = 8'h0F,
  parameter logic [RW-1:0] CTRL_MASK = 8'hCF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [3:0]    strap_addr,
  input  logic [3:0]    sig_ok,
  output logic [RW-1:0] route_cfg,
  output logic [RW-1:0] ctrl_cfg
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int CW = $clog2(RW + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_WDAT, S_RDAT, S_WAIT} st_t;

  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  st_t  state, nxt;
  logic [CW-1:0] cnt;
  logic [RW-1:0] shreg, tx, ptr, rd_val;
  logic [TW-1:0] tmo;
  logic ack_pend, ack_ph, mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_q, scl_s, scl_m} <= 3'b111;
      {sda_q, sda_s, sda_m} <= 3'b111;
    end else begin
      {scl_q, scl_s, scl_m} <= {scl_s, scl_m, scl_in};
      {sda_q, sda_s, sda_m} <= {sda_s, sda_m, sda_in};
    end
  end

  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire tmo_hit  = (tmo == TW'(TIMEOUT_CYC - 1)) & ~scl_s;
  wire [RW-1:0] byte_in = {shreg[RW-2:0], sda_s};
  wire rx_state = (state == S_ADDR) | (state == S_REG) | (state == S_WDAT);

  always_comb begin
    case (ptr)
      8'h00:   rd_val = route_cfg;
      8'h03:   rd_val = ctrl_cfg;
      8'h04:   rd_val = {4'b0000, sig_ok};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; nxt <= S_IDLE; cnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      tmo <= '0; ack_pend <= 1'b0; ack_ph <= 1'b0; sda_oe <= 1'b0; mode_q <= 1'b0;
      route_cfg <= '0; ctrl_cfg <= CTRL_RST;
    end else begin
      mode_q <= mode_en;
      if (state == S_IDLE || scl_s) tmo <= '0;
      else if (!tmo_hit)            tmo <= tmo + 1'b1;

      if (!mode_en || tmo_hit || stop_c) begin
        state <= S_IDLE; sda_oe <= 1'b0; ack_pend <= 1'b0; ack_ph <= 1'b0;
      end else if (start_c) begin
        state <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; ack_pend <= 1'b0; ack_ph <= 1'b0;
      end else if (scl_rise && rx_state && !ack_ph) begin
        shreg <= byte_in;
        if (cnt == CW'(RW - 1)) begin
          cnt <= '0;
          case (state)
            S_ADDR:
              if (byte_in[7:1] == {ADDR_PREFIX, strap_addr}) begin
                ack_pend <= 1'b1;
                nxt <= byte_in[0] ? S_RDAT : S_REG;
              end else state <= S_WAIT;
            S_REG: begin
              ptr <= byte_in; ack_pend <= 1'b1; nxt <= S_WDAT;
            end
            default: begin
              if (ptr == 8'h00) route_cfg <= byte_in;
              if (ptr == 8'h03) ctrl_cfg  <= byte_in & CTRL_MASK;
              ack_pend <= 1'b1; nxt <= S_WAIT;
            end
          endcase
        end else cnt <= cnt + 1'b1;
      end else if (scl_rise && state == S_RDAT) begin
        cnt <= cnt + 1'b1;
      end else if (scl_fall) begin
        if (ack_pend) begin
          sda_oe <= 1'b1; ack_pend <= 1'b0; ack_ph <= 1'b1;
        end else if (ack_ph) begin
          ack_ph <= 1'b0; state <= nxt; cnt <= '0;
          if (nxt == S_RDAT) begin
            tx <= rd_val; sda_oe <= ~rd_val[RW-1];
          end else sda_oe <= 1'b0;
        end else if (state == S_RDAT) begin
          if (cnt == CW'(RW)) begin
            sda_oe <= 1'b0; state <= S_WAIT;
          end else begin
            tx <= {tx[RW-2:0], 1'b0}; sda_oe <= ~tx[RW-2];
          end
        end
      end

      if (mode_en != mode_q) begin
        route_cfg <= '0; ctrl_cfg <= CTRL_RST;
      end
    end
  end

  assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !sda_oe);

  assert_mode_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en != mode_q) |=> (route_cfg == '0 && ctrl_cfg == CTRL_RST));

  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (!sda_oe && state == S_IDLE));

  assert_sda_low_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && $past(mode_en) && !$stable(sda_oe)) |-> !scl_q);

  assert_ctrl_holes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDAT && ptr == 8'h03 && !$stable(ctrl_cfg)) |-> ctrl_cfg[5:4] == 2'b00);
endmodule

// File: tb/tb_smb_regfile.sv
module tb_smb_regfile;
  localparam int Q = 6;
  localparam int TMO = 200;

  logic clk = 0, rst_n = 0, mode_en = 1;
  logic scl_drv = 1, sda_drv = 1;
  logic [3:0] strap = 4'b0110, sig = 4'b0000;
  logic sda_oe;
  logic [7:0] route_cfg, ctrl_cfg;
  wire line = sda_drv & ~sda_oe;

  int nchk = 0, nerr = 0;
  logic [7:0] m_route = 8'h00, m_ctrl = 8'h0F;
  logic [6:0] me;

  always #4 clk = ~clk;

  smb_regfile #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .scl_in(scl_drv), .sda_in(line),
    .sda_oe(sda_oe), .strap_addr(strap), .sig_ok(sig),
    .route_cfg(route_cfg), .ctrl_cfg(ctrl_cfg));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] r);
    case (r)
      8'h00:   return m_route;
      8'h03:   return m_ctrl;
      8'h04:   return {4'b0000, sig};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic [7:0] r, input logic [7:0] d);
    if (r == 8'h00) m_route = d;
    if (r == 8'h03) m_ctrl = d & 8'hCF;
  endfunction

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic bstart;
    sda_drv = 1; wq; scl_drv = 1; wq; sda_drv = 0; wq; scl_drv = 0; wq;
  endtask

  task automatic bstop;
    sda_drv = 0; wq; scl_drv = 1; wq; sda_drv = 1; wq;
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b; wq; scl_drv = 1; wq; wq; scl_drv = 0; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_drv = 1; wq; scl_drv = 1; wq; ack = line; wq; scl_drv = 0; wq;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sda_drv = 1; wq; scl_drv = 1; wq; d = {d[6:0], line}; wq; scl_drv = 0; wq;
    end
    put_bit(1'b1);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d, output logic [2:0] k);
    bstart; send_byte({a, 1'b0}, k[2]); send_byte(r, k[1]); send_byte(d, k[0]); bstop;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] r, output logic [7:0] d, output logic [2:0] k);
    bstart; send_byte({a, 1'b0}, k[2]); send_byte(r, k[1]);
    bstart; send_byte({a, 1'b1}, k[0]); recv_byte(d); bstop;
  endtask

  task automatic wr_chk(input logic [7:0] r, input logic [7:0] d, input string req);
    logic [2:0] k;
    wr(me, r, d, k);
    model_wr(r, d);
    chk(k == 3'b000, req, k, 0);
    chk(route_cfg == m_route && ctrl_cfg == m_ctrl, req, {route_cfg, ctrl_cfg}, {m_route, m_ctrl});
  endtask

  task automatic rd_chk(input logic [7:0] r, input string req);
    logic [2:0] k; logic [7:0] d;
    rd(me, r, d, k);
    chk(k == 3'b000, req, k, 0);
    chk(d == exp_read(r), req, d, exp_read(r));
  endtask

  bit done = 0;
  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    logic [2:0] k; logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    me = {3'b101, strap};
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(route_cfg == 8'h00 && ctrl_cfg == 8'h0F && !sda_oe, "R7 reset", {route_cfg, ctrl_cfg}, 16'h000F);

    rd_chk(8'h03, "R3 ctrl reset read");
    wr_chk(8'h00, 8'hA5, "R2 write route");
    rd_chk(8'h00, "R4 read route");
    wr_chk(8'h03, 8'hFF, "R3 ctrl masked");
    rd_chk(8'h03, "R3 ctrl read");
    sig = 4'b1010;
    rd_chk(8'h04, "R5 status read");
    wr_chk(8'h04, 8'h55, "R5 status write ignored");
    rd_chk(8'h04, "R5 status after write");
    wr_chk(8'h07, 8'h33, "R6 unmapped write");
    rd_chk(8'h07, "R6 unmapped read");

    wr({3'b101, 4'b0111}, 8'h00, 8'h11, k);
    chk(k == 3'b111, "R1 mismatch nack", k, 7);
    chk(route_cfg == m_route, "R1 mismatch no write", route_cfg, m_route);
    wr({3'b001, strap}, 8'h00, 8'h22, k);
    chk(k == 3'b111, "R1 prefix mismatch nack", k, 7);

    for (int i = 0; i < 30; i++) begin
      logic [7:0] r;
      case ($urandom % 5)
        0: r = 8'h00; 1: r = 8'h03; 2: r = 8'h04; 3: r = 8'h07;
        default: r = 8'($urandom);
      endcase
      sig = 4'($urandom);
      if ($urandom % 2) wr_chk(r, 8'($urandom), "R2 random write");
      else rd_chk(r, "R4 random read");
    end

    wr_chk(8'h00, 8'h3C, "R2 pre-mode write");
    mode_en = 0;
    repeat (4) @(negedge clk);
    m_route = 8'h00; m_ctrl = 8'h0F;
    chk(route_cfg == 8'h00 && ctrl_cfg == 8'h0F, "R7 mode fall reset", {route_cfg, ctrl_cfg}, 16'h000F);
    wr(me, 8'h00, 8'h77, k);
    chk(k == 3'b111, "R8 off ignores bus", k, 7);
    chk(route_cfg == 8'h00, "R8 off no write", route_cfg, 0);
    mode_en = 1;
    repeat (4) @(negedge clk);
    chk(route_cfg == 8'h00 && ctrl_cfg == 8'h0F, "R7 mode rise reset", {route_cfg, ctrl_cfg}, 16'h000F);
    wr_chk(8'h03, 8'h81, "R3 write after mode");

    bstart;
    for (int i = 7; i >= 0; i--) put_bit(i == 0 ? 1'b0 : me[i-1]);
    sda_drv = 1;
    repeat (TMO - 20) @(negedge clk);
    chk(sda_oe == 1'b1, "R9 ack held before timeout", sda_oe, 1);
    repeat (40) @(negedge clk);
    chk(sda_oe == 1'b0, "R9 released after timeout", sda_oe, 0);
    scl_drv = 1; wq; wq; scl_drv = 0; wq;
    send_byte(8'h00, k[0]);
    chk(k[0] == 1'b1, "R9 idle after timeout", k[0], 1);
    bstop;
    chk(route_cfg == m_route, "R9 no write after timeout", route_cfg, m_route);
    rd_chk(8'h03, "R9 recovers");

    finish_run;
  end
endmodule